// File: doc/BRIEF.md
# Oversampled PCM/DSD Serial Audio Receiver

This block takes a serial audio link made of three wires (bit clock, word-select line and data line) and recovers audio from it without ever using the source's bit clock as a clock. A fast local clock samples all three wires. The bit clock is treated as ordinary data: the receiver looks for a sampled low-then-high pattern on it, and at that point it takes the current word-select and data values. Jitter on the incoming edges therefore never reaches any register clock pin. The incoming master clock is not connected.

The same pins can carry two formats. In PCM mode, standard I2S framing yields a left/right pair of 24-bit words with a frame strobe. In raw DSD mode, the data wire and the word-select wire each carry one channel's one-bit stream, and the block delivers one bit pair per bit-clock period. A mode input can force either format or leave the choice to an automatic detector. The detector relies on the fact that the word-select line of a PCM link holds its level for long runs, while a DSD channel does not. If the bit clock stops, the block clears its outputs.

Top module: `osr_audio_rx`

## Requirements
- R1: The bit clock, word-select and data inputs each pass through a two-flop synchronizer on `clk`. Exactly one capture is made for each low-to-high change of the synchronized bit clock, however long the bit clock then stays high.
- R2: `mode_sel_i` encoding: 2'b01 forces PCM, 2'b10 forces DSD, and 2'b00 and 2'b11 both select automatic detection. Only the strobe of the active format ever pulses, and `fmt_dsd_o` is 1 while DSD is active.
- R3: PCM framing is I2S. Word-select low marks the left slot and high marks the right slot. The MSB of a word is the capture that follows a word-select change. `pcm_valid_o` pulses once per frame, at the capture where word-select returns low, and `pcm_left_o`/`pcm_right_o` then hold that frame's words.
- R4: In PCM mode the first 24 bits of each slot are kept. Bits after the 24th in a slot have no effect on the outputs.
- R5: A PCM slot shorter than 24 bits gives a word that is left-aligned, with zeros in its unused low bits.
- R6: In DSD mode, each capture produces one `dsd_valid_o` pulse. `dsd_left_o` takes the data wire and `dsd_right_o` takes the word-select wire.
- R7: Auto-detect works over windows of 64 captures. A window votes PCM if word-select stayed constant for at least 16 consecutive captures, and DSD otherwise. The active format changes only after 4 consecutive windows vote against it. After reset the format is PCM.
- R8: If 256 clocks pass without a capture, `stream_ok_o` drops to 0 and all data outputs clear to 0. `stream_ok_o` rises again after the next strobe.
- R9: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast local sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Asynchronous serial bit clock, sampled as data |
| lrck_i | input | 1 | Asynchronous word-select line, or the DSD right channel |
| sdat_i | input | 1 | Asynchronous serial data line, or the DSD left channel |
| mode_sel_i | input | 2 | Format select: 01 PCM, 10 DSD, 00/11 auto |
| pcm_left_o | output | 24 | Left PCM word, left-aligned |
| pcm_right_o | output | 24 | Right PCM word, left-aligned |
| pcm_valid_o | output | 1 | One-cycle strobe per PCM frame |
| dsd_left_o | output | 1 | Left DSD bit |
| dsd_right_o | output | 1 | Right DSD bit |
| dsd_valid_o | output | 1 | One-cycle strobe per DSD bit pair |
| fmt_dsd_o | output | 1 | Active format: 1 DSD, 0 PCM |
| stream_ok_o | output | 1 | Stream present; low after a bit-clock timeout |

## Verification
The bench targets the alignment of the word to the word-select change. It sends words with both the MSB and the LSB set, so a receiver off by one capture returns a shifted or wrapped word. It sends padded 32-bit slots and short 16-bit slots, which expose a receiver that does not stop at 24 bits or does not left-align. On the DSD side, it checks each wire is routed to the correct channel and that a long-held bit clock still gives exactly one capture. A receiver that re-captured while the bit clock stays high would produce extra strobes. The detector is driven both ways. It must not switch before four windows agree, it must switch after that, and it must return to PCM. Idle gaps are placed just under and well over the timeout, which catches a timeout counter with the wrong limit.

// File: rtl/osr_pkg.sv
package osr_pkg;
  typedef enum logic [1:0] {
    MODE_AUTO  = 2'b00,
    MODE_PCM   = 2'b01,
    MODE_DSD   = 2'b10,
    MODE_AUTO2 = 2'b11
  } osr_mode_e;

  typedef struct packed {
    logic bclk;
    logic lr;
    logic dat;
  } osr_pins_t;
endpackage

// File: rtl/osr_sync.sv
module osr_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= din;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/osr_capture.sv
module osr_capture #(
  parameter int QUIET_CLKS = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_s,
  input  logic lr_s,
  input  logic dat_s,
  output logic cap_o,
  output logic cap_lr_o,
  output logic cap_dat_o,
  output logic quiet_o
);
  localparam int IDLE_W = $clog2(QUIET_CLKS + 1);

  logic              bclk_prev_q;
  logic              rise;
  logic [IDLE_W-1:0] idle_q;

  assign rise = bclk_s && !bclk_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_prev_q <= 1'b0;
      cap_o       <= 1'b0;
      cap_lr_o    <= 1'b0;
      cap_dat_o   <= 1'b0;
      quiet_o     <= 1'b0;
      idle_q      <= IDLE_W'(QUIET_CLKS);
    end else begin
      bclk_prev_q <= bclk_s;
      cap_o       <= rise;
      if (rise) begin
        cap_lr_o  <= lr_s;
        cap_dat_o <= dat_s;
      end
      quiet_o <= !rise && (idle_q == IDLE_W'(QUIET_CLKS - 1));
      if (rise)                              idle_q <= '0;
      else if (idle_q != IDLE_W'(QUIET_CLKS)) idle_q <= idle_q + 1'b1;
    end
  end

  // R1: a capture needs a low sample in between, so two never come back to back
  p_single_capture_r1: assert property (@(posedge clk) disable iff (rst)
    cap_o |=> !cap_o);
endmodule

// File: rtl/osr_pcm_deser.sv
module osr_pcm_deser #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush_i,
  input  logic                cap_i,
  input  logic                lr_i,
  input  logic                dat_i,
  input  logic                en_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  localparam int CNT_W = $clog2(SAMPLE_W + 1);

  logic [SAMPLE_W-1:0] acc_q, acc_nx, aligned, held_q;
  logic [CNT_W-1:0]    cnt_q, cnt_nx;
  logic                prev_lr_q, primed_q, synced_q, have_left_q, lr_edge;

  always_comb begin
    acc_nx = acc_q;
    cnt_nx = cnt_q;
    if (cnt_q < CNT_W'(SAMPLE_W)) begin
      acc_nx = {acc_q[SAMPLE_W-2:0], dat_i};
      cnt_nx = cnt_q + 1'b1;
    end
    aligned = acc_nx << (CNT_W'(SAMPLE_W) - cnt_nx);
    lr_edge = primed_q && (lr_i != prev_lr_q);
  end

  always_ff @(posedge clk) begin
    if (rst || flush_i) begin
      acc_q       <= '0;
      cnt_q       <= '0;
      held_q      <= '0;
      prev_lr_q   <= 1'b0;
      primed_q    <= 1'b0;
      synced_q    <= 1'b0;
      have_left_q <= 1'b0;
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (cap_i) begin
        prev_lr_q <= lr_i;
        primed_q  <= 1'b1;
        if (lr_edge) begin
          synced_q <= 1'b1;
          acc_q    <= '0;
          cnt_q    <= '0;
          if (synced_q && en_i) begin
            if (!prev_lr_q) begin
              held_q      <= aligned;
              have_left_q <= 1'b1;
            end else if (have_left_q) begin
              left_o      <= held_q;
              right_o     <= aligned;
              valid_o     <= 1'b1;
              have_left_q <= 1'b0;
            end
          end
        end else begin
          acc_q <= acc_nx;
          cnt_q <= cnt_nx;
        end
      end
    end
  end

  // R3: a frame is released only by a capture that sees word-select low
  p_emit_at_left_start_r3: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> ($past(cap_i) && !$past(lr_i)));

  // R4: the bit counter never passes the kept word length
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(SAMPLE_W));
endmodule

// File: rtl/osr_fmt_detect.sv
module osr_fmt_detect #(
  parameter int RUN_MIN   = 16,
  parameter int WIN_LEN   = 64,
  parameter int HOLD_WINS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cap_i,
  input  logic lr_i,
  output logic is_dsd_o
);
  localparam int RUN_W  = $clog2(RUN_MIN + 1);
  localparam int WIN_W  = $clog2(WIN_LEN);
  localparam int HOLD_W = $clog2(HOLD_WINS + 1);

  logic [RUN_W-1:0]  run_q, run_nx;
  logic [WIN_W-1:0]  win_q;
  logic [HOLD_W-1:0] agree_q;
  logic              prev_lr_q, seen_q, seen_nx, win_end, vote_dsd;

  always_comb begin
    if (lr_i != prev_lr_q)                  run_nx = RUN_W'(1);
    else if (run_q == RUN_W'(RUN_MIN))      run_nx = run_q;
    else                                    run_nx = run_q + 1'b1;
    seen_nx  = seen_q || (run_nx == RUN_W'(RUN_MIN));
    win_end  = cap_i && (win_q == WIN_W'(WIN_LEN - 1));
    vote_dsd = !seen_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= '0;
      win_q     <= '0;
      agree_q   <= '0;
      prev_lr_q <= 1'b0;
      seen_q    <= 1'b0;
      is_dsd_o  <= 1'b0;
    end else if (cap_i) begin
      prev_lr_q <= lr_i;
      run_q     <= run_nx;
      if (win_end) begin
        win_q  <= '0;
        seen_q <= 1'b0;
        if (vote_dsd != is_dsd_o) begin
          if (agree_q == HOLD_W'(HOLD_WINS - 1)) begin
            is_dsd_o <= vote_dsd;
            agree_q  <= '0;
          end else begin
            agree_q <= agree_q + 1'b1;
          end
        end else begin
          agree_q <= '0;
        end
      end else begin
        win_q  <= win_q + 1'b1;
        seen_q <= seen_nx;
      end
    end
  end

  // R7: the decision moves only on a window boundary
  p_switch_at_window_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(is_dsd_o) || $fell(is_dsd_o)) |-> $past(win_end));
endmodule

// File: rtl/osr_audio_rx.sv
module osr_audio_rx #(
  parameter int SAMPLE_W    = 24,
  parameter int SYNC_STAGES = 2,
  parameter int QUIET_CLKS  = 256,
  parameter int LR_RUN      = 16,
  parameter int DET_WIN     = 64,
  parameter int DET_HOLD    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bclk_i,
  input  logic                lrck_i,
  input  logic                sdat_i,
  input  logic [1:0]          mode_sel_i,
  output logic [SAMPLE_W-1:0] pcm_left_o,
  output logic [SAMPLE_W-1:0] pcm_right_o,
  output logic                pcm_valid_o,
  output logic                dsd_left_o,
  output logic                dsd_right_o,
  output logic                dsd_valid_o,
  output logic                fmt_dsd_o,
  output logic                stream_ok_o
);
  import osr_pkg::*;

  osr_pins_t pins_raw, pins_s;
  osr_mode_e mode_q;
  logic      cap, cap_lr, cap_dat, quiet, det_dsd, active_dsd;

  assign pins_raw = '{bclk: bclk_i, lr: lrck_i, dat: sdat_i};

  osr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (pins_raw),
    .dout(pins_s)
  );

  osr_capture #(.QUIET_CLKS(QUIET_CLKS)) u_capture (
    .clk      (clk),
    .rst      (rst),
    .bclk_s   (pins_s.bclk),
    .lr_s     (pins_s.lr),
    .dat_s    (pins_s.dat),
    .cap_o    (cap),
    .cap_lr_o (cap_lr),
    .cap_dat_o(cap_dat),
    .quiet_o  (quiet)
  );

  osr_fmt_detect #(.RUN_MIN(LR_RUN), .WIN_LEN(DET_WIN), .HOLD_WINS(DET_HOLD)) u_detect (
    .clk     (clk),
    .rst     (rst),
    .cap_i   (cap),
    .lr_i    (cap_lr),
    .is_dsd_o(det_dsd)
  );

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_AUTO;
    else     mode_q <= osr_mode_e'(mode_sel_i);
  end

  always_comb begin
    case (mode_q)
      MODE_PCM: active_dsd = 1'b0;
      MODE_DSD: active_dsd = 1'b1;
      default:  active_dsd = det_dsd;
    endcase
  end

  osr_pcm_deser #(.SAMPLE_W(SAMPLE_W)) u_pcm (
    .clk    (clk),
    .rst    (rst),
    .flush_i(quiet),
    .cap_i  (cap),
    .lr_i   (cap_lr),
    .dat_i  (cap_dat),
    .en_i   (!active_dsd),
    .left_o (pcm_left_o),
    .right_o(pcm_right_o),
    .valid_o(pcm_valid_o)
  );

  always_ff @(posedge clk) begin
    if (rst || quiet) begin
      dsd_left_o  <= 1'b0;
      dsd_right_o <= 1'b0;
      dsd_valid_o <= 1'b0;
    end else begin
      dsd_valid_o <= cap && active_dsd;
      if (cap && active_dsd) begin
        dsd_left_o  <= cap_dat;
        dsd_right_o <= cap_lr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_dsd_o   <= 1'b0;
      stream_ok_o <= 1'b0;
    end else begin
      fmt_dsd_o <= active_dsd;
      if (quiet)                            stream_ok_o <= 1'b0;
      else if (pcm_valid_o || dsd_valid_o)  stream_ok_o <= 1'b1;
    end
  end

  // R2: the two format strobes never pulse together
  p_excl_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    !(pcm_valid_o && dsd_valid_o));

  // R6: every DSD strobe comes from a capture made while DSD was active
  p_dsd_from_capture_r6: assert property (@(posedge clk) disable iff (rst)
    dsd_valid_o |-> ($past(cap) && $past(active_dsd)));

  // R8: a timeout drops the stream flag and clears the data
  p_quiet_clears_r8: assert property (@(posedge clk) disable iff (rst)
    quiet |=> (!stream_ok_o && pcm_left_o == '0 && !dsd_left_o));
endmodule

// File: tb/osr_audio_rx_bench.sv
module osr_audio_rx_bench;
  localparam int W = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic         bclk = 1'b0, lrck = 1'b0, sdat = 1'b0;
  logic [1:0]   mode_sel = 2'b00;
  logic [W-1:0] pcm_left, pcm_right;
  logic         pcm_valid, dsd_left, dsd_right, dsd_valid, fmt_dsd, stream_ok;

  osr_audio_rx u_osr_audio_rx (
    .clk        (clk),
    .rst        (rst),
    .bclk_i     (bclk),
    .lrck_i     (lrck),
    .sdat_i     (sdat),
    .mode_sel_i (mode_sel),
    .pcm_left_o (pcm_left),
    .pcm_right_o(pcm_right),
    .pcm_valid_o(pcm_valid),
    .dsd_left_o (dsd_left),
    .dsd_right_o(dsd_right),
    .dsd_valid_o(dsd_valid),
    .fmt_dsd_o  (fmt_dsd),
    .stream_ok_o(stream_ok)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic [W-1:0] got_l [64];
  logic [W-1:0] got_r [64];
  logic         got_dl [512];
  logic         got_dr [512];
  int n_pcm = 0, n_dsd = 0;

  always @(negedge clk) begin
    if (pcm_valid) begin
      if (n_pcm < 64) begin got_l[n_pcm] = pcm_left; got_r[n_pcm] = pcm_right; end
      n_pcm++;
    end
    if (dsd_valid) begin
      if (n_dsd < 512) begin got_dl[n_dsd] = dsd_left; got_dr[n_dsd] = dsd_right; end
      n_dsd++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic lr, input logic d, input int high_clks);
    bclk = 1'b0; lrck = lr; sdat = d;
    repeat (4) @(negedge clk);
    bclk = 1'b1;
    repeat (high_clks) @(negedge clk);
  endtask

  task automatic idle(input int n);
    bclk = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [W-1:0] word_l(input int f);
    if (f == 0) return 24'h800001;
    return W'((f * 32'h0B1D37 + 32'h1234) ^ 32'hA50F3C);
  endfunction

  function automatic logic [W-1:0] word_r(input int f);
    logic [W-1:0] l;
    if (f == 0) return 24'hFFFFFF;
    l = word_l(f);
    return {l[11:0], l[23:12]} ^ 24'h5A5A5A ^ W'(f);
  endfunction

  // I2S stream: data runs one bit behind word-select
  task automatic send_pcm(input int frames, input int slot);
    logic last = 1'b0;
    logic [W-1:0] w;
    for (int k = 0; k < 4; k++) send_bit(1'b1, 1'b0, 4);
    for (int f = 0; f < frames; f++) begin
      for (int ch = 0; ch < 2; ch++) begin
        w = ch ? word_r(f) : word_l(f);
        for (int j = 0; j < slot; j++) begin
          logic d;
          if (j == 0) d = last;
          else d = ((j - 1) < W) ? w[W-j] : 1'b0;
          send_bit(ch[0], d, 4);
        end
        last = (slot - 1 < W) ? w[W-slot] : 1'b0;
      end
    end
    send_bit(1'b0, last, 4);
  endtask

  function automatic logic dsd_lbit(input int i);
    return i[0] ^ i[3] ^ i[5];
  endfunction
  function automatic logic dsd_rbit(input int i);
    return i[1] ^ i[2];
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    logic [W-1:0] mask16;
    mask16 = 24'hFFFF00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9: reset state
    check("R9 pcm_left", 32'(pcm_left), 0);
    check("R9 valids", {30'd0, pcm_valid, dsd_valid}, 0);
    check("R9 flags", {30'd0, fmt_dsd, stream_ok}, 0);

    // R3/R4: auto mode with 32-bit slots, padding after 24 bits
    mode_sel = 2'b00;
    base = n_pcm;
    send_pcm(6, 32);
    idle(4);
    check("R3 frame count", 32'(n_pcm - base), 6);
    for (int f = 0; f < 6; f++) begin
      check("R3 left word", 32'(got_l[base + f]), 32'(word_l(f)));
      check("R4 right word", 32'(got_r[base + f]), 32'(word_r(f)));
    end
    check("R7 stays PCM", 32'(fmt_dsd), 0);
    check("R8 stream up", 32'(stream_ok), 1);

    // R8: gap shorter than the timeout keeps state, longer one clears
    idle(150);
    check("R8 no early timeout", 32'(stream_ok), 1);
    idle(200);
    check("R8 timeout flag", 32'(stream_ok), 0);
    check("R8 cleared left", 32'(pcm_left), 0);
    check("R8 cleared right", 32'(pcm_right), 0);

    // R5: forced PCM, 16-bit slots
    mode_sel = 2'b01;
    base = n_pcm;
    send_pcm(4, 16);
    idle(4);
    check("R5 frame count", 32'(n_pcm - base), 4);
    for (int f = 0; f < 4; f++) begin
      check("R5 left short", 32'(got_l[base + f]), 32'(word_l(f) & mask16));
      check("R5 right short", 32'(got_r[base + f]), 32'(word_r(f) & mask16));
    end
    idle(300);

    // R7: auto mode fed DSD must wait, then switch
    mode_sel = 2'b00;
    for (int i = 0; i < 200; i++) send_bit(dsd_rbit(i), dsd_lbit(i), 4);
    check("R7 hold before switch", 32'(fmt_dsd), 0);
    base = n_dsd;
    for (int i = 200; i < 500; i++) send_bit(dsd_rbit(i), dsd_lbit(i), 4);
    idle(4);
    check("R7 switched to DSD", 32'(fmt_dsd), 1);
    check("R7 DSD strobes after switch", 32'(n_dsd - base > 0), 1);

    // R7/R2: auto via code 11 returns to PCM
    mode_sel = 2'b11;
    send_pcm(8, 32);
    idle(4);
    check("R2 R7 back to PCM", 32'(fmt_dsd), 0);
    idle(300);

    // R6/R2: forced DSD, exact bit pairs, no PCM strobes
    mode_sel = 2'b10;
    base = n_dsd;
    begin
      int pbase;
      pbase = n_pcm;
      for (int i = 0; i < 40; i++) send_bit(dsd_rbit(i + 7), dsd_lbit(i + 7), 4);
      idle(4);
      check("R6 pair count", 32'(n_dsd - base), 40);
      for (int i = 0; i < 40; i++) begin
        check("R6 left from data", 32'(got_dl[base + i]), 32'(dsd_lbit(i + 7)));
        check("R6 right from lr", 32'(got_dr[base + i]), 32'(dsd_rbit(i + 7)));
      end
      check("R2 no PCM strobe in DSD", 32'(n_pcm - pbase), 0);
      check("R2 fmt forced DSD", 32'(fmt_dsd), 1);
    end

    // R1: long high bit clock still gives one capture per bit
    base = n_dsd;
    for (int i = 0; i < 5; i++) send_bit(1'b0, 1'b1, 40);
    idle(4);
    check("R1 one capture per rise", 32'(n_dsd - base), 5);
    idle(300);
    check("R8 DSD cleared", {30'd0, dsd_left, stream_ok}, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule